// File: doc/BRIEF.md
# BCD Timecode Match Comparator

This block watches the time values produced by a timecode reader and reports when they reach a target time set by the host. The target is held as four packed-BCD bytes for frames, seconds, minutes and hours. The comparison is evaluated only in the cycle in which the reader signals a new frame. The flag bits that share the time bytes are masked off on both sides before comparing.

The host arms one comparison by flipping the arm bit in a control byte. On the first qualifying frame, the block copies that bit into its status byte and pulses an event. The event also drives a maskable interrupt. The block then stays idle until the host flips the arm bit again. Two match rules are available. The exact rule requires equal time. The window rule accepts any time from the target up to, but not including, one second after it. The target plus one second is computed in BCD and wraps at midnight.

Top module: `tc_match_cmp`

## Requirements
- R1: After reset, `cmp_status`, `irq_evt` and `irq` are 0 and the comparator is not armed, so a frame equal to the target produces no event.
- R2: Host writes with `wr_addr` 0, 1, 2, 3 load the target frames, seconds, minutes and hours bytes. Address 4 loads the control byte: bit 4 is the arm toggle, and bit 0 selects the rule (1 = window, 0 = exact).
- R3: A comparison happens only in a cycle with `frame_stb` high. The resulting event and status change are visible from the cycle after that strobe.
- R4: Under the exact rule, a match means all four bytes are equal once the ignored bits are cleared. The ignored bits are frames bits 7:6, seconds bit 7, minutes bit 7 and hours bits 7:6.
- R5: Under the window rule, a match means target <= current < target + 1 s. Values are ordered as hours:minutes:seconds:frames. The +1 s carries in BCD through minutes and hours, wraps from 23:59:59 to 00:00:00 and keeps the frames field.
- R6: A control write whose bit 4 differs from the stored bit 4 arms the comparator. On a match, status bit 4 takes the value of control bit 4, `irq_evt` pulses for one cycle and the comparator disarms. Later matching frames give no event until the next toggle.
- R7: A toggle written while the comparator is already armed leaves it armed, even when the new bit 4 equals status bit 4.
- R8: Status bit 7 (active) clears when the comparator is armed. It sets on the first non-matching strobed frame while armed, and clears on a match.
- R9: `irq` is `irq_evt` gated by `irq_en` as sampled at the matching edge.
- R10: A control write that leaves bit 4 unchanged does not arm the comparator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | New reader frame, one cycle |
| cur_frames | input | 8 | Reader frames, packed BCD with flags |
| cur_seconds | input | 8 | Reader seconds, packed BCD |
| cur_minutes | input | 8 | Reader minutes, packed BCD |
| cur_hours | input | 8 | Reader hours, packed BCD |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Host register select |
| wr_data | input | 8 | Host write data |
| irq_en | input | 1 | Interrupt mask enable |
| cmp_status | output | 8 | Bit 7 active, bit 4 match toggle, rest 0 |
| irq_evt | output | 1 | Match event pulse |
| irq | output | 1 | Masked interrupt pulse |

## Verification
The assertions assume that `frame_stb` is low during reset and on the cycle that follows it. They also assume that the time inputs and target bytes carry valid BCD digits, with hours in the range 00 to 23. The stimulus only ever drives legal times, produced by a bench function that converts integers to BCD. It sets arbitrary patterns on the flag bits only. Host writes and frame strobes are never issued in the same cycle, so the arming order the assertions rely on is never contested.

// File: rtl/tc_cmp_pkg.sv
package tc_cmp_pkg;
  localparam int BYTE_W    = 8;
  localparam int TGT_BYTES = 4;

  // Field order gives magnitude order: hours most significant.
  typedef struct packed {
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] mn;
    logic [BYTE_W-1:0] sc;
    logic [BYTE_W-1:0] fr;
  } tc_t;

  localparam logic [BYTE_W-1:0] FR_KEEP = 8'h3F;
  localparam logic [BYTE_W-1:0] SC_KEEP = 8'h7F;
  localparam logic [BYTE_W-1:0] MN_KEEP = 8'h7F;
  localparam logic [BYTE_W-1:0] HR_KEEP = 8'h3F;

  function automatic tc_t tc_mask(tc_t t);
    tc_t m;
    m.hr = t.hr & HR_KEEP;
    m.mn = t.mn & MN_KEEP;
    m.sc = t.sc & SC_KEEP;
    m.fr = t.fr & FR_KEEP;
    return m;
  endfunction
endpackage

// File: rtl/bcd_tc_inc.sv
module bcd_tc_inc
  import tc_cmp_pkg::*;
#(
  parameter logic [7:0] HOUR_LAST = 8'h23,
  parameter logic [3:0] DIGIT_MAX = 4'd9,
  parameter logic [3:0] TENS_MAX  = 4'd5
) (
  input  tc_t  tc_in,
  output tc_t  tc_out,
  output logic wrapped
);
  // Returns {carry, next} for a base-60 BCD pair.
  function automatic logic [8:0] inc_b60(logic [7:0] b);
    logic [8:0] r;
    if (b[3:0] != DIGIT_MAX)       r = {1'b0, b[7:4], b[3:0] + 4'd1};
    else if (b[7:4] < TENS_MAX)    r = {1'b0, b[7:4] + 4'd1, 4'd0};
    else                           r = 9'h100;
    return r;
  endfunction

  logic [8:0] sec_n, min_n;
  logic [7:0] hr_n;
  logic       hr_wrap;

  always_comb begin
    sec_n = inc_b60(tc_in.sc);
    min_n = inc_b60(tc_in.mn);
    hr_wrap = (tc_in.hr == HOUR_LAST);
    if (hr_wrap)                       hr_n = 8'h00;
    else if (tc_in.hr[3:0] == DIGIT_MAX) hr_n = {tc_in.hr[7:4] + 4'd1, 4'd0};
    else                               hr_n = {tc_in.hr[7:4], tc_in.hr[3:0] + 4'd1};
  end

  always_comb begin
    tc_out    = tc_in;
    wrapped   = 1'b0;
    tc_out.sc = sec_n[7:0];
    if (sec_n[8]) begin
      tc_out.mn = min_n[7:0];
      if (min_n[8]) begin
        tc_out.hr = hr_n;
        wrapped   = hr_wrap;
      end
    end
  end
endmodule

// File: rtl/tc_window_cmp.sv
module tc_window_cmp
  import tc_cmp_pkg::*;
#(
  parameter logic [7:0] HOUR_LAST = 8'h23
) (
  input  tc_t  cur,
  input  tc_t  tgt,
  output logic exact_eq,
  output logic win_hit
);
  tc_t  cur_m, tgt_m, tgt_nx;
  logic nx_wrap, ge_lo, lt_hi;

  assign cur_m = tc_mask(cur);
  assign tgt_m = tc_mask(tgt);

  bcd_tc_inc #(.HOUR_LAST(HOUR_LAST)) u_inc (
    .tc_in  (tgt_m),
    .tc_out (tgt_nx),
    .wrapped(nx_wrap)
  );

  always_comb begin
    ge_lo    = (cur_m >= tgt_m);
    lt_hi    = (cur_m <  tgt_nx);
    exact_eq = (cur_m == tgt_m);
    // Across midnight the window is split in two pieces.
    win_hit  = nx_wrap ? (ge_lo || lt_hi) : (ge_lo && lt_hi);
  end
endmodule

// File: rtl/tc_match_cmp.sv
module tc_match_cmp
  import tc_cmp_pkg::*;
#(
  parameter int         ADDR_W      = 3,
  parameter int         CTL_ADDR    = 4,
  parameter int         ARM_BIT     = 4,
  parameter int         RULE_BIT    = 0,
  parameter int         ACT_BIT     = 7,
  parameter bit         RULE_RESET  = 1'b1,
  parameter logic [7:0] HOUR_LAST   = 8'h23
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_stb,
  input  logic [7:0]        cur_frames,
  input  logic [7:0]        cur_seconds,
  input  logic [7:0]        cur_minutes,
  input  logic [7:0]        cur_hours,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              irq_en,
  output logic [7:0]        cmp_status,
  output logic              irq_evt,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] CTL_SEL = ADDR_W'(CTL_ADDR);

  logic [BYTE_W-1:0] tgt_b [TGT_BYTES];

  for (genvar gi = 0; gi < TGT_BYTES; gi++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst)                                       tgt_b[gi] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(gi))      tgt_b[gi] <= wr_data;
    end
  end

  tc_t  tgt_tc, cur_tc;
  logic exact_eq, win_hit;

  assign tgt_tc = '{hr: tgt_b[3], mn: tgt_b[2], sc: tgt_b[1], fr: tgt_b[0]};
  assign cur_tc = '{hr: cur_hours, mn: cur_minutes, sc: cur_seconds, fr: cur_frames};

  tc_window_cmp #(.HOUR_LAST(HOUR_LAST)) u_cmp (
    .cur     (cur_tc),
    .tgt     (tgt_tc),
    .exact_eq(exact_eq),
    .win_hit (win_hit)
  );

  logic ctl_tog, ctl_rule, stat_tog, armed, active;
  logic ctl_wr, tog_wr, hit;

  assign ctl_wr = wr_en && (wr_addr == CTL_SEL);
  assign tog_wr = ctl_wr && (wr_data[ARM_BIT] != ctl_tog);
  assign hit    = frame_stb && armed && (ctl_rule ? win_hit : exact_eq);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_tog  <= 1'b0;
      ctl_rule <= RULE_RESET;
      stat_tog <= 1'b0;
      armed    <= 1'b0;
      active   <= 1'b0;
      irq_evt  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (ctl_wr) begin
        ctl_tog  <= wr_data[ARM_BIT];
        ctl_rule <= wr_data[RULE_BIT];
      end
      if (hit) stat_tog <= ctl_tog;
      if (tog_wr)                   armed <= 1'b1;
      else if (hit)                 armed <= 1'b0;
      if (tog_wr || hit)            active <= 1'b0;
      else if (frame_stb && armed)  active <= 1'b1;
      irq_evt <= hit;
      irq     <= hit && irq_en;
    end
  end

  always_comb begin
    cmp_status          = '0;
    cmp_status[ACT_BIT] = active;
    cmp_status[ARM_BIT] = stat_tog;
  end

  // R6: the status toggle only moves together with an event
  a_r6_status_moves_with_event: assert property (@(posedge clk) disable iff (rst)
    !$stable(stat_tog) |-> irq_evt);
  // R3: an event always follows a strobed frame
  a_r3_event_needs_frame: assert property (@(posedge clk) disable iff (rst)
    irq_evt |-> $past(frame_stb));
  // R6: an event leaves the comparator disarmed unless re-armed meanwhile
  a_r6_event_disarms: assert property (@(posedge clk) disable iff (rst)
    (irq_evt && !$past(tog_wr)) |-> !armed);
  // R9: the masked interrupt never fires without the raw event
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq |-> irq_evt);
  // R8: active is only shown while armed
  a_r8_active_needs_arm: assert property (@(posedge clk) disable iff (rst)
    active |-> armed);
  // R5: an exact match always lies inside the window
  a_r5_exact_in_window: assert property (@(posedge clk) disable iff (rst)
    exact_eq |-> win_hit);
endmodule

// File: tb/sim_tc_match_cmp.sv
module sim_tc_match_cmp;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0;
  logic [7:0] cur_frames = '0, cur_seconds = '0, cur_minutes = '0, cur_hours = '0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic irq_en = 1'b0;
  logic [7:0] cmp_status;
  logic irq_evt, irq;

  always #10 clk = ~clk;  // 50 MHz

  tc_match_cmp u0 (
    .clk(clk), .rst(rst), .frame_stb(frame_stb),
    .cur_frames(cur_frames), .cur_seconds(cur_seconds),
    .cur_minutes(cur_minutes), .cur_hours(cur_hours),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .irq_en(irq_en),
    .cmp_status(cmp_status), .irq_evt(irq_evt), .irq(irq)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model
  bit m_ctl = 0, m_stat = 0, m_armed = 0, m_active = 0, m_win = 1;
  int t_sec = 0, t_fr = 0;

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  task automatic check(bit cond, string req, int act, int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // R2: address 0..3 = frames, seconds, minutes, hours
  task automatic set_target(int h, int m, int s, int f, int fl);
    host_wr(0, bcd(f) | 8'((fl & 3) << 6));
    host_wr(1, bcd(s) | 8'((fl & 1) << 7));
    host_wr(2, bcd(m) | 8'((fl & 2) << 6));
    host_wr(3, bcd(h) | 8'(((fl + 1) & 3) << 6));
    t_sec = h * 3600 + m * 60 + s; t_fr = f;
  endtask

  task automatic ctl_wr(bit tog, bit win);
    logic [7:0] d;
    d = 8'h00; d[4] = tog; d[0] = win;
    if (tog != m_ctl) begin m_armed = 1; m_active = 0; end
    m_ctl = tog; m_win = win;
    host_wr(4, d);
  endtask

  function automatic bit model_hit(int cs, int cf);
    int tt, cc, t1;
    tt = t_sec * 100 + t_fr;
    cc = cs * 100 + cf;
    t1 = ((t_sec + 1) % 86400) * 100 + t_fr;
    if (!m_win) return cc == tt;
    if (t1 > tt) return (cc >= tt) && (cc < t1);
    return (cc >= tt) || (cc < t1);
  endfunction

  task automatic frame(int cs, int cf, int fl, bit ien, string req);
    bit exp_hit;
    logic [7:0] exp_st;
    exp_hit = m_armed && model_hit(cs, cf);
    @(negedge clk);
    frame_stb = 1'b1; irq_en = ien;
    cur_frames  = bcd(cf) | 8'((fl & 3) << 6);
    cur_seconds = bcd(cs % 60) | 8'((fl & 4) << 5);
    cur_minutes = bcd((cs / 60) % 60) | 8'((fl & 8) << 4);
    cur_hours   = bcd(cs / 3600) | 8'((fl & 3) << 6);
    if (exp_hit) begin m_stat = m_ctl; m_armed = 0; m_active = 0; end
    else if (m_armed) m_active = 1;
    @(negedge clk);
    frame_stb = 1'b0;
    exp_st = {m_active, 2'b00, m_stat, 4'h0};
    check(irq_evt == exp_hit, {req, " event"}, irq_evt, exp_hit);
    check(cmp_status == exp_st, {req, " status"}, cmp_status, exp_st);
    check(irq == (exp_hit && ien), "R9 irq", irq, exp_hit && ien);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  int tgts[6][4] = '{'{0,0,0,5}, '{0,0,59,29}, '{9,59,59,0},
                     '{19,59,59,12}, '{23,59,59,20}, '{12,34,56,7}};

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(cmp_status == 8'h00, "R1 status", cmp_status, 0);
    check(irq_evt == 1'b0 && irq == 1'b0, "R1 irq", irq_evt, 0);
    frame(0, 0, 0, 1, "R1");
    // R10 write with unchanged toggle does not arm
    ctl_wr(0, 0);
    frame(0, 0, 0, 1, "R10");
    // R3 no strobe, no compare
    ctl_wr(1, 0);
    cur_frames = 0; cur_seconds = 0; cur_minutes = 0; cur_hours = 0;
    repeat (4) @(negedge clk);
    check(irq_evt == 1'b0 && cmp_status == 8'h00, "R3 no strobe", cmp_status, 0);
    frame(1, 0, 0, 1, "R8 miss");
    frame(0, 0, 0, 1, "R3 hit");
    // R6 one shot
    frame(0, 0, 0, 1, "R6 one-shot");
    // R7 double toggle keeps armed
    ctl_wr(0, 0);
    ctl_wr(1, 0);
    frame(0, 0, 3, 0, "R7");
    // R4/R5 sweep
    for (int ti = 0; ti < 6; ti++) begin
      set_target(tgts[ti][0], tgts[ti][1], tgts[ti][2], tgts[ti][3], ti);
      for (int w = 0; w < 2; w++) begin
        ctl_wr(!m_ctl, w[0]);
        for (int ds = -2; ds <= 2; ds++) begin
          for (int fi = 0; fi < 5; fi++) begin
            int cf, cs;
            case (fi)
              0: cf = 0;
              1: cf = (t_fr > 0) ? t_fr - 1 : 0;
              2: cf = t_fr;
              3: cf = (t_fr < 29) ? t_fr + 1 : 29;
              default: cf = 29;
            endcase
            cs = (t_sec + ds + 86400) % 86400;
            if (!m_armed) ctl_wr(!m_ctl, w[0]);
            frame(cs, cf, ds + fi + ti + 2, fi[0], w ? "R5" : "R4");
          end
        end
      end
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule